// File: doc/BRIEF.md
# Paravirtual Device Legacy Register Block

This block is the I/O-mapped control window of a legacy paravirtual PCI device. A host issues single-cycle read and write requests on a simple bus. The block decodes them against a small common header. The header covers feature negotiation, a queue selector, the base address and size of the selected queue, queue kick notification, a device status byte and an interrupt status byte that clears when read. When message-signalled interrupts are in use, it also holds a configuration vector and a per-queue vector. Accesses beyond the header pass straight through to a device-specific configuration window, with the offset rebased to zero.

The block stores each queue's base address and vector and exposes them to the ring engine. It turns notify writes into a one-cycle kick pulse that carries the queue index. It drives the legacy level interrupt from the interrupt status byte. A zero written to the status byte, or a zero page frame written for a queue, returns all software-visible state to its reset values.

Top module: `pv_legacy_regs`

## Requirements
- R1: A read of word 0 (byte offset 0) returns `dev_feat_i` with bits 24 (notify on empty), 28 (indirect descriptors) and 30 (bad-feature marker) forced to one. Writes to word 0 have no effect.
- R2: A write to word 1 (offset 4) merges the enabled byte lanes into the stored guest features. If bit 30 of the merged value is set, parameter `FALLBACK_FEAT` is stored in its place. A read of word 1 returns the stored value.
- R3: A write to word 2 (offset 8) merges the enabled lanes into the selected queue's page frame number and stores it. That queue's `q_base_o` field then equals the frame number shifted left by 12. A read returns the frame number. A merged value of zero stores nothing and causes a full reset instead.
- R4: Lanes 3:2 of word 3 (offset 14) hold the 16-bit queue select. A write is kept only if the merged value is below `NQ`; otherwise the previous selection stays. Lanes 1:0 (offset 12) read the selected queue's size from `q_size_i` and ignore writes.
- R5: Lane 2 of word 4 (offset 18) is the device status byte. A write with a value of zero triggers a full reset. A full reset clears guest features, status, interrupt status, queue select and every page frame number, and sets every vector to 0xFFFF. The same state results from `rst_ni`.
- R6: Lane 3 of word 4 (offset 19) is the interrupt status byte. Bits set in `isr_set_i` are ORed into it. A read with lane 3 enabled returns the old value and clears the byte. A bit set in the same cycle as a clearing read is kept.
- R7: When `msix_en_i` is low, `intx_o` equals bit 0 of the interrupt status byte. When it is high, `intx_o` is low.
- R8: A write to word 4 with lane 0 or 1 enabled is a notify. The index is formed from the enabled low lanes, with disabled lanes taken as zero. If the index is below `NQ`, the cycle after the write `notify_o` pulses high for one cycle and `notify_idx_o` shows the index. Otherwise nothing happens.
- R9: Word 5 (offset 20) exists only while `msix_en_i` is high. Lanes 1:0 hold the configuration vector and lanes 3:2 hold the selected queue's vector. A merged write value below `NVEC` is stored; any other value stores 0xFFFF.
- R10: The header is 20 bytes with `msix_en_i` low and 24 bytes with it high. A request at or above the header length asserts `win_req_o` in the same cycle, with `win_addr_o` equal to the address minus the header length. Its read data is `win_rdata_i` as it stands during that request.
- R11: Registers are word addressed (`addr_i[1:0]` ignored). `be_i` selects the byte lanes. On a header read, disabled lanes return 0xFF, and the notify halfword (word 4, lanes 1:0) always reads 0xFFFF.
- R12: A read request asserts `rvalid_o` in the following cycle, with `rdata_o` holding the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msix_en_i | input | 1 | Message-signalled interrupts enabled |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address within the region |
| be_i | input | 4 | Byte lane enables |
| wdata_i | input | 32 | Write data, lane aligned |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| dev_feat_i | input | 32 | Device feature mask |
| q_size_i | input | NQ*16 | Per-queue ring sizes |
| isr_set_i | input | 8 | Interrupt events to OR into status |
| intx_o | output | 1 | Legacy level interrupt |
| notify_o | output | 1 | Queue kick pulse |
| notify_idx_o | output | 16 | Kicked queue index |
| q_base_o | output | NQ*(PFN_W+12) | Per-queue base addresses |
| q_vec_o | output | NQ*16 | Per-queue vectors |
| cfg_vec_o | output | 16 | Configuration-change vector |
| win_req_o | output | 1 | Device window request |
| win_we_o | output | 1 | Device window write |
| win_addr_o | output | ADDR_W | Rebased window offset |
| win_be_o | output | 4 | Device window lane enables |
| win_wdata_o | output | 32 | Device window write data |
| win_rdata_i | input | 32 | Device window read data |

## Verification
A device event on `isr_set_i` can arrive in the same cycle as a host read that acknowledges the interrupt status byte. A status-zero write can likewise coincide with a new event. The bench provokes both on purpose in directed steps and also at random, by driving event bits with every bus access. A reference model then predicts the old byte on the read data, and predicts that only the event bits survive into the next cycle. The expected `intx_o` level follows from that model.

// File: rtl/pv_regs_pkg.sv
package pv_regs_pkg;
  localparam int unsigned FEAT_NOTIFY_EMPTY = 24;
  localparam int unsigned FEAT_INDIRECT     = 28;
  localparam int unsigned FEAT_BAD          = 30;
  localparam logic [31:0] FEAT_FORCED = (32'd1 << FEAT_NOTIFY_EMPTY) |
                                        (32'd1 << FEAT_INDIRECT) |
                                        (32'd1 << FEAT_BAD);
  localparam logic [15:0] NO_VEC = 16'hFFFF;
  localparam int unsigned HDR_BYTES_INTX = 20;
  localparam int unsigned HDR_BYTES_MSIX = 24;

  typedef enum logic [2:0] {
    W_HOSTF   = 3'd0,
    W_GUESTF  = 3'd1,
    W_PFN     = 3'd2,
    W_QSZ_SEL = 3'd3,
    W_NTF_STS = 3'd4,
    W_VEC     = 3'd5
  } hdr_word_e;

  function automatic logic [31:0] lane_merge(input logic [31:0] cur, input logic [31:0] nxt,
                                             input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? nxt[b*8 +: 8] : cur[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [15:0] lane_merge16(input logic [15:0] cur, input logic [15:0] nxt,
                                               input logic [1:0] be);
    logic [15:0] r;
    for (int b = 0; b < 2; b++) r[b*8 +: 8] = be[b] ? nxt[b*8 +: 8] : cur[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [15:0] vec_grant(input logic [15:0] v, input int unsigned nvec);
    return (32'(v) < nvec) ? v : NO_VEC;
  endfunction
endpackage

// File: rtl/pv_addr_split.sv
module pv_addr_split
  import pv_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              msix_en_i,
  output logic              hdr_hit_o,
  output hdr_word_e         word_o,
  output logic [ADDR_W-1:0] win_off_o
);
  logic [ADDR_W-1:0] hdr_len;

  always_comb begin
    hdr_len   = msix_en_i ? ADDR_W'(HDR_BYTES_MSIX) : ADDR_W'(HDR_BYTES_INTX);
    hdr_hit_o = addr_i < hdr_len;
    word_o    = hdr_word_e'(addr_i[4:2]);
    win_off_o = addr_i - hdr_len;
  end
endmodule

// File: rtl/pv_queue_bank.sv
module pv_queue_bank
  import pv_regs_pkg::*;
#(
  parameter  int unsigned NQ     = 4,
  parameter  int unsigned PFN_W  = 32,
  parameter  int unsigned NVEC   = 8,
  localparam int unsigned QSEL_W = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic [QSEL_W-1:0]   sel_i,
  input  logic                pfn_we_i,
  input  logic [PFN_W-1:0]    pfn_i,
  input  logic                vec_we_i,
  input  logic [15:0]         vec_i,
  output logic [PFN_W-1:0]    sel_pfn_o,
  output logic [15:0]         sel_vec_o,
  output logic [NQ*PFN_W-1:0] pfn_all_o,
  output logic [NQ*16-1:0]    vec_all_o
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [PFN_W-1:0] pfn_q;
    logic [15:0]      vec_q;
    logic             hit;

    assign hit = sel_i == QSEL_W'(q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pfn_q <= '0;
        vec_q <= NO_VEC;
      end else if (soft_rst_i) begin
        pfn_q <= '0;
        vec_q <= NO_VEC;
      end else begin
        if (pfn_we_i && hit) pfn_q <= pfn_i;
        if (vec_we_i && hit) vec_q <= vec_grant(vec_i, NVEC);
      end
    end

    assign pfn_all_o[q*PFN_W +: PFN_W] = pfn_q;
    assign vec_all_o[q*16 +: 16]       = vec_q;

    p_vec_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(vec_q) < NVEC) || (vec_q == NO_VEC));
  end

  assign sel_pfn_o = pfn_all_o[32'(sel_i)*PFN_W +: PFN_W];
  assign sel_vec_o = vec_all_o[32'(sel_i)*16 +: 16];

  p_soft_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (pfn_all_o == '0));
endmodule

// File: rtl/pv_isr_unit.sv
module pv_isr_unit #(
  parameter int unsigned ISR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             ack_i,
  input  logic [ISR_W-1:0] set_i,
  output logic [ISR_W-1:0] isr_o
);
  logic [ISR_W-1:0] isr_q;

  // new events win over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= ((soft_rst_i || ack_i) ? '0 : isr_q) | set_i;
  end

  assign isr_o = isr_q;

  p_event_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((isr_o & $past(set_i)) == $past(set_i)));

  p_ack_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !(|set_i)) |=> (isr_o == '0));
endmodule

// File: rtl/pv_legacy_regs.sv
module pv_legacy_regs
  import pv_regs_pkg::*;
#(
  parameter  int unsigned NQ            = 4,
  parameter  int unsigned NVEC          = 8,
  parameter  int unsigned ADDR_W        = 8,
  parameter  int unsigned PFN_W         = 32,
  parameter  logic [31:0] FALLBACK_FEAT = 32'h0,
  localparam int unsigned QSEL_W        = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int unsigned BASE_W        = PFN_W + 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 msix_en_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [3:0]           be_i,
  input  logic [31:0]          wdata_i,
  output logic                 rvalid_o,
  output logic [31:0]          rdata_o,
  input  logic [31:0]          dev_feat_i,
  input  logic [NQ*16-1:0]     q_size_i,
  input  logic [7:0]           isr_set_i,
  output logic                 intx_o,
  output logic                 notify_o,
  output logic [15:0]          notify_idx_o,
  output logic [NQ*BASE_W-1:0] q_base_o,
  output logic [NQ*16-1:0]     q_vec_o,
  output logic [15:0]          cfg_vec_o,
  output logic                 win_req_o,
  output logic                 win_we_o,
  output logic [ADDR_W-1:0]    win_addr_o,
  output logic [3:0]           win_be_o,
  output logic [31:0]          win_wdata_o,
  input  logic [31:0]          win_rdata_i
);
  logic              hdr_hit;
  hdr_word_e         word;
  logic [ADDR_W-1:0] win_off;

  pv_addr_split #(.ADDR_W(ADDR_W)) u_split (
    .addr_i   (addr_i),
    .msix_en_i(msix_en_i),
    .hdr_hit_o(hdr_hit),
    .word_o   (word),
    .win_off_o(win_off)
  );

  logic              acc_wr, acc_rd;
  logic [31:0]       gfeat_q;
  logic [7:0]        status_q;
  logic [QSEL_W-1:0] qsel_q;
  logic [15:0]       cfg_vec_q;
  logic [PFN_W-1:0]  sel_pfn;
  logic [15:0]       sel_vec;
  logic [7:0]        isr_q;
  logic [NQ*PFN_W-1:0] pfn_all;

  logic [31:0] gfeat_m, pfn_m32;
  logic [15:0] sel_m, ntf_m, cfg_m, qv_m;
  logic wr_gf, wr_pfn, pfn_zero, wr_sel, sel_ok, wr_ntf, ntf_ok, wr_sts;
  logic wr_cfgv, wr_qv, soft_rst, isr_ack;

  assign acc_wr = req_i & we_i & hdr_hit;
  assign acc_rd = req_i & ~we_i & hdr_hit;

  always_comb begin
    gfeat_m  = lane_merge(gfeat_q, wdata_i, be_i);
    pfn_m32  = lane_merge(32'(sel_pfn), wdata_i, be_i);
    sel_m    = lane_merge16(16'(qsel_q), wdata_i[31:16], be_i[3:2]);
    ntf_m    = lane_merge16(16'h0, wdata_i[15:0], be_i[1:0]);
    cfg_m    = lane_merge16(cfg_vec_q, wdata_i[15:0], be_i[1:0]);
    qv_m     = lane_merge16(sel_vec, wdata_i[31:16], be_i[3:2]);

    wr_gf    = acc_wr && word == W_GUESTF && |be_i;
    wr_pfn   = acc_wr && word == W_PFN && |be_i;
    pfn_zero = pfn_m32[PFN_W-1:0] == '0;
    wr_sel   = acc_wr && word == W_QSZ_SEL && |be_i[3:2];
    sel_ok   = 32'(sel_m) < NQ;
    wr_ntf   = acc_wr && word == W_NTF_STS && |be_i[1:0];
    ntf_ok   = 32'(ntf_m) < NQ;
    wr_sts   = acc_wr && word == W_NTF_STS && be_i[2];
    wr_cfgv  = acc_wr && word == W_VEC && |be_i[1:0];
    wr_qv    = acc_wr && word == W_VEC && |be_i[3:2];
    soft_rst = (wr_pfn && pfn_zero) || (wr_sts && wdata_i[23:16] == 8'h00);
    isr_ack  = acc_rd && word == W_NTF_STS && be_i[3];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gfeat_q   <= '0;
      status_q  <= '0;
      qsel_q    <= '0;
      cfg_vec_q <= NO_VEC;
    end else if (soft_rst) begin
      gfeat_q   <= '0;
      status_q  <= '0;
      qsel_q    <= '0;
      cfg_vec_q <= NO_VEC;
    end else begin
      if (wr_gf)           gfeat_q   <= gfeat_m[FEAT_BAD] ? FALLBACK_FEAT : gfeat_m;
      if (wr_sel && sel_ok) qsel_q   <= sel_m[QSEL_W-1:0];
      if (wr_sts)          status_q  <= wdata_i[23:16];
      if (wr_cfgv)         cfg_vec_q <= vec_grant(cfg_m, NVEC);
    end
  end

  pv_queue_bank #(.NQ(NQ), .PFN_W(PFN_W), .NVEC(NVEC)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst),
    .sel_i     (qsel_q),
    .pfn_we_i  (wr_pfn && !pfn_zero),
    .pfn_i     (pfn_m32[PFN_W-1:0]),
    .vec_we_i  (wr_qv),
    .vec_i     (qv_m),
    .sel_pfn_o (sel_pfn),
    .sel_vec_o (sel_vec),
    .pfn_all_o (pfn_all),
    .vec_all_o (q_vec_o)
  );

  pv_isr_unit #(.ISR_W(8)) u_isr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst),
    .ack_i     (isr_ack),
    .set_i     (isr_set_i),
    .isr_o     (isr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      notify_o     <= 1'b0;
      notify_idx_o <= '0;
    end else begin
      notify_o <= wr_ntf && ntf_ok;
      if (wr_ntf && ntf_ok) notify_idx_o <= ntf_m;
    end
  end

  logic [31:0] raw_rd, hdr_rd;
  always_comb begin
    unique case (word)
      W_HOSTF:   raw_rd = dev_feat_i | FEAT_FORCED;
      W_GUESTF:  raw_rd = gfeat_q;
      W_PFN:     raw_rd = 32'(sel_pfn);
      W_QSZ_SEL: raw_rd = {16'(qsel_q), q_size_i[32'(qsel_q)*16 +: 16]};
      W_NTF_STS: raw_rd = {isr_q, status_q, 16'hFFFF};
      W_VEC:     raw_rd = {sel_vec, cfg_vec_q};
      default:   raw_rd = '1;
    endcase
    for (int b = 0; b < 4; b++) hdr_rd[b*8 +: 8] = be_i[b] ? raw_rd[b*8 +: 8] : 8'hFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= req_i & ~we_i;
      if (req_i && !we_i) rdata_o <= hdr_hit ? hdr_rd : win_rdata_i;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_base
    assign q_base_o[q*BASE_W +: BASE_W] = {pfn_all[q*PFN_W +: PFN_W], 12'h000};
  end

  assign cfg_vec_o   = cfg_vec_q;
  assign intx_o      = ~msix_en_i & isr_q[0];
  assign win_req_o   = req_i & ~hdr_hit;
  assign win_we_o    = we_i;
  assign win_addr_o  = win_off;
  assign win_be_o    = be_i;
  assign win_wdata_o = wdata_i;

  p_rvalid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  p_notify_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |-> (32'(notify_idx_o) < NQ));

  p_qsel_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(qsel_q) < NQ);

  p_intx_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msix_en_i |-> !intx_o);

  p_status_reset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts && wdata_i[23:16] == 8'h00) |=> (status_q == 8'h00 && cfg_vec_o == NO_VEC));

  p_win_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_req_o |-> !(acc_wr || acc_rd));
endmodule

// File: tb/pv_legacy_regs_bench.sv
module pv_legacy_regs_bench;
  import pv_regs_pkg::*;

  localparam int unsigned NQ = 4;
  localparam int unsigned NVEC = 8;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned PFN_W = 32;
  localparam int unsigned BASE_W = PFN_W + 12;
  localparam logic [31:0] FALLBACK = 32'h0000_0013;
  localparam logic [31:0] DEV_FEAT = 32'h0000_0A21;
  localparam logic [31:0] WIN_XOR = 32'hA5C3_0F96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msix = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0;
  logic rvalid;
  logic [31:0] rdata;
  logic [NQ*16-1:0] q_size;
  logic [7:0] isr_set = '0;
  logic intx, notify;
  logic [15:0] notify_idx;
  logic [NQ*BASE_W-1:0] q_base;
  logic [NQ*16-1:0] q_vec;
  logic [15:0] cfg_vec;
  logic win_req, win_we;
  logic [ADDR_W-1:0] win_addr;
  logic [3:0] win_be;
  logic [31:0] win_wdata, win_rdata;

  always #4 clk = ~clk;

  assign win_rdata = {win_addr, win_addr, win_addr, win_addr} ^ WIN_XOR;

  for (genvar q = 0; q < NQ; q++) begin : g_sz
    assign q_size[q*16 +: 16] = 16'(32 << q);
  end

  pv_legacy_regs #(.NQ(NQ), .NVEC(NVEC), .ADDR_W(ADDR_W), .PFN_W(PFN_W),
                   .FALLBACK_FEAT(FALLBACK)) u_pv_legacy_regs (
    .clk_i(clk), .rst_ni(rst_n), .msix_en_i(msix), .req_i(req), .we_i(we),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata),
    .dev_feat_i(DEV_FEAT), .q_size_i(q_size), .isr_set_i(isr_set), .intx_o(intx),
    .notify_o(notify), .notify_idx_o(notify_idx), .q_base_o(q_base), .q_vec_o(q_vec),
    .cfg_vec_o(cfg_vec), .win_req_o(win_req), .win_we_o(win_we), .win_addr_o(win_addr),
    .win_be_o(win_be), .win_wdata_o(win_wdata), .win_rdata_i(win_rdata)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] m_gf, m_pfn [NQ];
  logic [7:0]  m_st, m_isr;
  logic [15:0] m_cv, m_qv [NQ];
  int unsigned m_qsel;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bmerge(input logic [31:0] c, input logic [31:0] n, input logic [3:0] e);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = e[b] ? n[b*8 +: 8] : c[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [15:0] grant(input logic [15:0] v);
    return (32'(v) < NVEC) ? v : 16'hFFFF;
  endfunction

  task automatic m_reset();
    m_gf = '0; m_st = '0; m_isr = '0; m_qsel = 0; m_cv = 16'hFFFF;
    for (int q = 0; q < NQ; q++) begin m_pfn[q] = '0; m_qv[q] = 16'hFFFF; end
  endtask

  function automatic logic [31:0] m_read(input int w, input logic [3:0] e);
    logic [31:0] r;
    case (w)
      0: r = DEV_FEAT | 32'h5100_0000;
      1: r = m_gf;
      2: r = m_pfn[m_qsel];
      3: r = {16'(m_qsel), 16'(32 << m_qsel)};
      4: r = {m_isr, m_st, 16'hFFFF};
      default: r = {m_qv[m_qsel], m_cv};
    endcase
    for (int b = 0; b < 4; b++) if (!e[b]) r[b*8 +: 8] = 8'hFF;
    return r;
  endfunction

  function automatic string rd_tag(input int w);
    case (w)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5 R6 R11";
      default: return "R9";
    endcase
  endfunction

  task automatic chk_state();
    chk(cfg_vec == m_cv, "R9", 64'(cfg_vec), 64'(m_cv));
    for (int q = 0; q < NQ; q++) begin
      chk(q_base[q*BASE_W +: BASE_W] == {m_pfn[q], 12'h000}, "R3",
          64'(q_base[q*BASE_W +: BASE_W]), 64'({m_pfn[q], 12'h000}));
      chk(q_vec[q*16 +: 16] == m_qv[q], "R9", 64'(q_vec[q*16 +: 16]), 64'(m_qv[q]));
    end
  endtask

  task automatic op(input bit w_en, input int a, input logic [3:0] e, input logic [31:0] d,
                    input logic [7:0] ev);
    int hdr, w;
    bit inhdr, clr, exp_n;
    logic [31:0] exp_rd, v;
    logic [15:0] exp_idx, h;
    @(negedge clk);
    req = 1'b1; we = w_en; addr = ADDR_W'(a); be = e; wdata = d; isr_set = ev;
    #1;
    hdr = msix ? 24 : 20;
    inhdr = a < hdr;
    w = a >> 2;
    chk(win_req == !inhdr, "R10", 64'(win_req), 64'(!inhdr));
    if (!inhdr) chk(win_addr == ADDR_W'(a - hdr), "R10", 64'(win_addr), 64'(a - hdr));
    exp_rd = inhdr ? m_read(w, e) : ({4{8'(a - hdr)}} ^ WIN_XOR);
    exp_n = 1'b0; exp_idx = '0; clr = 1'b0;
    if (inhdr && !w_en && w == 4 && e[3]) clr = 1'b1;
    if (inhdr && w_en) begin
      case (w)
        1: if (|e) begin v = bmerge(m_gf, d, e); m_gf = v[30] ? FALLBACK : v; end
        2: if (|e) begin
             v = bmerge(m_pfn[m_qsel], d, e);
             if (v == 0) begin m_reset(); clr = 1'b1; end else m_pfn[m_qsel] = v;
           end
        3: if (|e[3:2]) begin
             h = bmerge({16'(m_qsel), 16'h0}, d, {e[3:2], 2'b00}) >> 16;
             if (32'(h) < NQ) m_qsel = 32'(h);
           end
        4: begin
             if (|e[1:0]) begin
               h = 16'(bmerge(32'h0, d, {2'b00, e[1:0]}));
               if (32'(h) < NQ) begin exp_n = 1'b1; exp_idx = h; end
             end
             if (e[2]) begin
               m_st = d[23:16];
               if (d[23:16] == 8'h00) begin m_reset(); clr = 1'b1; end
             end
           end
        5: begin
             if (|e[1:0]) m_cv = grant(16'(bmerge({16'h0, m_cv}, d, {2'b00, e[1:0]})));
             if (|e[3:2]) m_qv[m_qsel] = grant(16'(bmerge({m_qv[m_qsel], 16'h0}, d, {e[3:2], 2'b00}) >> 16));
           end
        default: ;
      endcase
    end
    m_isr = (clr ? 8'h00 : m_isr) | ev;
    @(negedge clk);
    req = 1'b0; isr_set = '0;
    if (!w_en) begin
      chk(rvalid == 1'b1, "R12", 64'(rvalid), 64'd1);
      chk(rdata == exp_rd, inhdr ? rd_tag(w) : "R10", 64'(rdata), 64'(exp_rd));
    end
    chk(notify == exp_n, "R8", 64'(notify), 64'(exp_n));
    if (exp_n) chk(notify_idx == exp_idx, "R8", 64'(notify_idx), 64'(exp_idx));
    chk(intx == (!msix && m_isr[0]), "R7", 64'(intx), 64'(!msix && m_isr[0]));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL R12: watchdog expired, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [3:0] be_set [8];
    be_set = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF, 4'h0};
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R5)
    chk(rvalid == 1'b0 && notify == 1'b0 && intx == 1'b0, "R5", 64'({rvalid, notify, intx}), 64'd0);
    chk_state();
    for (int w = 0; w < 5; w++) op(1'b0, w * 4, 4'hF, 32'h0, 8'h0);

    // features (R1, R2)
    op(1'b1, 0, 4'hF, 32'hFFFF_FFFF, 8'h0);
    op(1'b0, 0, 4'hF, 32'h0, 8'h0);
    op(1'b1, 4, 4'hF, 32'h4000_0005, 8'h0);
    op(1'b0, 4, 4'hF, 32'h0, 8'h0);
    op(1'b1, 4, 4'h1, 32'hFFFF_FF6C, 8'h0);
    op(1'b0, 4, 4'hF, 32'h0, 8'h0);

    // page frame and select (R3, R4)
    op(1'b1, 8, 4'hF, 32'h0001_2345, 8'h0);
    op(1'b1, 12, 4'hC, 32'h0002_0000, 8'h0);
    op(1'b1, 8, 4'h3, 32'h0000_0777, 8'h0);
    op(1'b1, 12, 4'hC, 32'h0007_0000, 8'h0);
    op(1'b0, 12, 4'hF, 32'h0, 8'h0);
    op(1'b1, 12, 4'h8, 32'h0100_0000, 8'h0);
    op(1'b0, 8, 4'hF, 32'h0, 8'h0);
    chk_state();

    // interrupt status with coinciding event (R6, R7)
    op(1'b1, 0, 4'h0, 32'h0, 8'h03);
    op(1'b0, 16, 4'h8, 32'h0, 8'h04);
    op(1'b0, 16, 4'hC, 32'h0, 8'h01);
    op(1'b0, 16, 4'h8, 32'h0, 8'h00);

    // notify (R8, R11)
    op(1'b1, 16, 4'h3, 32'h0000_0003, 8'h0);
    op(1'b1, 16, 4'h3, 32'h0000_0004, 8'h0);
    op(1'b1, 16, 4'h1, 32'hFFFF_FF02, 8'h0);
    op(1'b0, 16, 4'h3, 32'h0, 8'h0);

    // vectors and window (R9, R10)
    op(1'b0, 20, 4'hF, 32'h0, 8'h0);
    msix = 1'b1;
    op(1'b1, 20, 4'h3, 32'h0000_0005, 8'h01);
    op(1'b1, 20, 4'hC, 32'h0002_0000, 8'h0);
    op(1'b0, 20, 4'hF, 32'h0, 8'h0);
    op(1'b1, 20, 4'h3, 32'h0000_0009, 8'h0);
    op(1'b0, 24, 4'hF, 32'h0, 8'h0);
    op(1'b0, 20, 4'hF, 32'h0, 8'h0);
    chk_state();

    // status reset paths (R5)
    op(1'b1, 16, 4'h4, 32'h0007_0000, 8'h0);
    op(1'b0, 16, 4'h4, 32'h0, 8'h0);
    op(1'b1, 16, 4'h4, 32'h0000_0000, 8'h02);
    chk_state();
    op(1'b0, 16, 4'hF, 32'h0, 8'h0);
    op(1'b1, 8, 4'hF, 32'h0000_0055, 8'h0);
    op(1'b1, 8, 4'hF, 32'h0000_0000, 8'h0);
    chk_state();
    msix = 1'b0;

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      logic [7:0] ev;
      if ($urandom % 50 == 0) msix = ~msix;
      case ($urandom % 6)
        0, 1: d = $urandom;
        2: d = $urandom % 10;
        3: d = ($urandom % 10) << 16;
        4: d = (($urandom % 3) << 16) | ($urandom % 6);
        default: d = 32'h0;
      endcase
      ev = ($urandom % 5 == 0) ? 8'(1 << ($urandom % 8)) : 8'h0;
      op(1'($urandom % 2), int'($urandom % 10) * 4, be_set[$urandom % 8], d, ev);
      if (i % 8 == 0) chk_state();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule